// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, in a single cycle, how a processor core enters an exception. Each cycle it looks at a vector of pending exception requests and picks one winner. It then works out everything the core must update to take that exception. It uses the current program counter, a flag that marks the faulting instruction as sitting in a branch delay slot, and the relevant status and control bits: exception level, boot vector, interrupt vector, debug mode and the exception base.

The result is registered. It appears one cycle later, together with a one-cycle `commit` pulse, and the core applies it at that point. The result contains:
- the next fetch address;
- write strobes and values for the three return-address registers (ordinary, error and debug);
- the exception code, the delay-slot bit and the coprocessor number of the cause register;
- set requests for the exception-level, error-level, boot-vector, non-maskable and soft-reset status bits;
- the debug-cause bits;
- the debug-mode entry request;
- the requests to drop the delay-slot flag and to force kernel mode.

The block does not execute instructions and does not flush the pipeline.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `commit` and every write or set strobe are 0.
- R2: If any `req` bit is set in a cycle, `commit` is 1 for exactly the following cycle, and the outputs of that cycle describe the winning request. A cycle with no request gives `commit` = 0 and no strobes in the next cycle.
- R3: The lowest-numbered `req` bit wins. The bit positions are: 0 soft reset, 1 NMI, 2 debug single-step, 3 debug interrupt, 4 debug instruction breakpoint, 5 debug break instruction, 6 debug data-store break, 7 debug data-load break, 8 refill-load, 9 refill-store, 10 invalid-load, 11 invalid-store, 12 modify, 13 address-error load, 14 address-error store, 15 interrupt, 16 instruction bus error, 17 data bus error, 18 syscall, 19 break, 20 reserved instruction, 21 coprocessor unusable, 22 overflow, 23 trap, 24 floating point, 25 machine check, 26 cache error. Only the winner produces effects.
- R4: For an ordinary exception (bits 8 to 26), the vector base is 0xBFC00200 when `bev` is 1. Otherwise it is `ebase` with its low 10 bits cleared. The default offset 0x180 is added to this base.
- R5: An interrupt uses offset 0x200 when `iv` is 1. A refill (bit 8 or 9) uses offset 0x000 when `exl` is 0 and 0x180 when `exl` is 1.
- R6: A cache error writes code 30 and uses offset 0x100 when `bev` is 1, and 0x20000100 when `bev` is 0.
- R7: For an ordinary exception with `exl` = 0, the block writes `epc_val` and `bd_val`. When `in_delay` is 1 these are `pc`−4 and 1. When `in_delay` is 0 they are `pc` and 0. The block also raises `set_exl`.
- R8: For an ordinary exception with `exl` = 1, `epc_we`, `bd_we` and `set_exl` stay 0, and the exception code is still written.
- R9: The exception codes are: interrupt 0, modify 1, refill/invalid load 2, refill/invalid store 3, address-error load 4, address-error store 5, instruction bus 6, data bus 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, machine check 24. Coprocessor unusable also writes `cop_num` through `ce_we`/`ce_val`.
- R10: NMI and soft reset write `errepc_val` (`pc`−4 when in a delay slot, otherwise `pc`). They raise `set_erl` and `set_bev`, and `set_nmi_flag` or `set_sr_flag` respectively. The next PC is 0xBFC00000. When `exl` = 0 they also clear BD (`bd_we`=1, `bd_val`=0).
- R11: A debug request writes `depc_val`: `pc`−4 when in a delay slot, except for single-step, which always uses `pc`. It raises `enter_debug` and jumps to 0xBFC00480. It sets exactly one `dbg_bits` bit, in the order: bit 0 single-step, 1 interrupt, 2 instruction breakpoint, 3 break instruction, 4 data store, 5 data load.
- R12: When `in_debug` is 1, an interrupt request (bit 15) is taken as a debug interrupt and writes no exception code.
- R13: Every committed entry raises `clear_delay` and `force_kernel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 27 | Exception request vector, one bit per kind |
| cop_num | input | 2 | Coprocessor number for coprocessor-unusable |
| pc | input | AW | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction is in a delay slot |
| exl | input | 1 | Exception level currently set |
| bev | input | 1 | Boot vectors selected |
| iv | input | 1 | Special interrupt vector selected |
| in_debug | input | 1 | Core currently in debug mode |
| ebase | input | AW | Exception base register |
| commit | output | 1 | One-cycle pulse: apply the outputs |
| next_pc | output | AW | Handler address |
| epc_we | output | 1 | Write ordinary return address |
| epc_val | output | AW | Ordinary return address |
| errepc_we | output | 1 | Write error return address |
| errepc_val | output | AW | Error return address |
| depc_we | output | 1 | Write debug return address |
| depc_val | output | AW | Debug return address |
| code_we | output | 1 | Write exception code field |
| code | output | 5 | Exception code |
| bd_we | output | 1 | Write delay-slot bit of cause |
| bd_val | output | 1 | Delay-slot bit value |
| ce_we | output | 1 | Write coprocessor number field |
| ce_val | output | 2 | Coprocessor number |
| set_exl | output | 1 | Set exception level |
| set_erl | output | 1 | Set error level |
| set_bev | output | 1 | Set boot-vector bit |
| set_nmi_flag | output | 1 | Set NMI status bit |
| set_sr_flag | output | 1 | Set soft-reset status bit |
| dbg_bits | output | 6 | Debug-cause bits to set |
| enter_debug | output | 1 | Enter debug mode |
| clear_delay | output | 1 | Drop the delay-slot flag |
| force_kernel | output | 1 | Force kernel mode |

## Verification
Two functions can fall in the same cycle. An interrupt can arrive while the core is in debug mode, so the interrupt remapping and the priority arbitration act on the same request. A debug or error-level request can also coincide with an ordinary fault. Directed tests provoke both by setting several `req` bits at once, with and without `in_debug`. The tests judge the outcome by which return-address strobe fires, which flag or debug bit is raised, and which handler address appears. Exactly one entry's effects may be visible.

// File: rtl/exc_entry_pkg.sv
// Package: request kinds, entry classes and exception-code lookup shared by
// the exception entry sequencer. Assumes the request bit index equals the
// kind value, and that a lower value means a higher priority.
package exc_entry_pkg;

    localparam int NUM_KINDS = 27;
    localparam int KIND_W    = $clog2(NUM_KINDS);
    localparam int CODE_W    = 5;
    localparam int DBG_W     = 6;

    typedef enum logic [KIND_W-1:0] {
        K_SRST   = 5'd0,  K_NMI    = 5'd1,
        K_DSS    = 5'd2,  K_DINT   = 5'd3,  K_DIBRK = 5'd4,
        K_DBRK   = 5'd5,  K_DDST   = 5'd6,  K_DDLD  = 5'd7,
        K_RFL_LD = 5'd8,  K_RFL_ST = 5'd9,
        K_INV_LD = 5'd10, K_INV_ST = 5'd11, K_MOD   = 5'd12,
        K_ADR_LD = 5'd13, K_ADR_ST = 5'd14,
        K_IRQ    = 5'd15, K_IBUS   = 5'd16, K_DBUS  = 5'd17,
        K_SYSC   = 5'd18, K_BRK    = 5'd19, K_RSVD  = 5'd20,
        K_COPU   = 5'd21, K_OVF    = 5'd22, K_TRAP  = 5'd23,
        K_FPE    = 5'd24, K_MCHK   = 5'd25, K_CACHE = 5'd26
    } kind_e;

    typedef enum logic [1:0] {CLS_NONE, CLS_ERR, CLS_DBG, CLS_ORD} class_e;

    // Map a kind to its entry class.
    function automatic class_e class_of(input kind_e k);
        if (k <= K_NMI)       return CLS_ERR;
        else if (k <= K_DDLD) return CLS_DBG;
        else                  return CLS_ORD;
    endfunction

    // Map an ordinary kind to the code written into the cause field.
    function automatic logic [CODE_W-1:0] code_of(input kind_e k);
        case (k)
            K_IRQ:            return 5'd0;
            K_MOD:            return 5'd1;
            K_RFL_LD, K_INV_LD: return 5'd2;
            K_RFL_ST, K_INV_ST: return 5'd3;
            K_ADR_LD:         return 5'd4;
            K_ADR_ST:         return 5'd5;
            K_IBUS:           return 5'd6;
            K_DBUS:           return 5'd7;
            K_SYSC:           return 5'd8;
            K_BRK:            return 5'd9;
            K_RSVD:           return 5'd10;
            K_COPU:           return 5'd11;
            K_OVF:            return 5'd12;
            K_TRAP:           return 5'd13;
            K_FPE:            return 5'd15;
            K_MCHK:           return 5'd24;
            K_CACHE:          return 5'd30;
            default:          return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Priority arbiter: remaps an interrupt taken in debug mode to a debug
// interrupt, then selects the lowest-numbered pending request.
// Assumes request bit i corresponds to kind value i.
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int N     = NUM_KINDS,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic          in_debug,
    output logic          hit,
    output logic [IW-1:0] win
);
    logic [N-1:0] eff;

    // Redirect an interrupt to the debug-interrupt slot while in debug mode.
    always_comb begin
        eff = req;
        if (in_debug) begin
            eff[K_IRQ]  = 1'b0;
            eff[K_DINT] = req[K_DINT] | req[K_IRQ];
        end
    end

    // Scan from the lowest priority upward so the lowest index wins.
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eff[i]) win = IW'(i);
        end
        hit = |eff;
    end
endmodule

// File: rtl/exc_vector.sv
// Handler address generator: computes the next fetch address for the
// winning kind from the boot/ordinary bases and the kind-specific offset.
// Assumes AW >= 32.
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          hit,
    input  kind_e         kind,
    input  logic          exl,
    input  logic          bev,
    input  logic          iv,
    input  logic [AW-1:0] ebase,
    output logic [AW-1:0] next_pc
);
    localparam logic [AW-1:0] BOOT_ORD = AW'(32'hBFC0_0200);
    localparam logic [AW-1:0] BOOT_ERR = AW'(32'hBFC0_0000);
    localparam logic [AW-1:0] BOOT_DBG = AW'(32'hBFC0_0480);
    localparam logic [AW-1:0] OFS_GEN  = AW'(32'h0000_0180);
    localparam logic [AW-1:0] OFS_IRQ  = AW'(32'h0000_0200);
    localparam logic [AW-1:0] OFS_CB   = AW'(32'h0000_0100);
    localparam logic [AW-1:0] OFS_CN   = AW'(32'h2000_0100);

    logic [AW-1:0] ord_base;
    logic [AW-1:0] ofs;

    // Select the ordinary base from the boot-vector bit or the base register.
    always_comb ord_base = bev ? BOOT_ORD : {ebase[AW-1:10], 10'b0};

    // Select the offset by kind and status.
    always_comb begin
        case (kind)
            K_RFL_LD, K_RFL_ST: ofs = exl ? OFS_GEN : '0;
            K_IRQ:              ofs = iv ? OFS_IRQ : OFS_GEN;
            K_CACHE:            ofs = bev ? OFS_CB : OFS_CN;
            default:            ofs = OFS_GEN;
        endcase
    end

    // Pick the final target by entry class.
    always_comb begin
        if (!hit) next_pc = '0;
        else begin
            case (class_of(kind))
                CLS_ERR: next_pc = BOOT_ERR;
                CLS_DBG: next_pc = BOOT_DBG;
                default: next_pc = ord_base + ofs;
            endcase
        end
    end
endmodule

// File: rtl/exc_capture.sv
// State-capture decoder: produces the return-address, cause and status
// updates for the winning kind. Assumes hit gates every strobe.
module exc_capture
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              hit,
    input  kind_e             kind,
    input  logic [AW-1:0]     pc,
    input  logic              in_delay,
    input  logic              exl,
    input  logic [1:0]        cop_num,
    output logic              epc_we,
    output logic [AW-1:0]     epc_val,
    output logic              errepc_we,
    output logic [AW-1:0]     errepc_val,
    output logic              depc_we,
    output logic [AW-1:0]     depc_val,
    output logic              code_we,
    output logic [CODE_W-1:0] code,
    output logic              bd_we,
    output logic              bd_val,
    output logic              ce_we,
    output logic [1:0]        ce_val,
    output logic              set_exl,
    output logic              set_erl,
    output logic              set_bev,
    output logic              set_nmi_flag,
    output logic              set_sr_flag,
    output logic [DBG_W-1:0]  dbg_bits,
    output logic              enter_debug,
    output logic              clear_delay,
    output logic              force_kernel
);
    logic [AW-1:0] pc_back;

    // Return address corrected back to the branch for delay-slot faults.
    always_comb pc_back = in_delay ? (pc - AW'(4)) : pc;

    // Decode all updates for the winning kind's class.
    always_comb begin
        epc_we = 1'b0; epc_val = '0; errepc_we = 1'b0; errepc_val = '0;
        depc_we = 1'b0; depc_val = '0; code_we = 1'b0; code = '0;
        bd_we = 1'b0; bd_val = 1'b0; ce_we = 1'b0; ce_val = '0;
        set_exl = 1'b0; set_erl = 1'b0; set_bev = 1'b0;
        set_nmi_flag = 1'b0; set_sr_flag = 1'b0; dbg_bits = '0;
        enter_debug = 1'b0;
        clear_delay  = hit;
        force_kernel = hit;
        if (hit) begin
            case (class_of(kind))
                CLS_ERR: begin
                    errepc_we    = 1'b1;
                    errepc_val   = pc_back;
                    set_erl      = 1'b1;
                    set_bev      = 1'b1;
                    set_sr_flag  = (kind == K_SRST);
                    set_nmi_flag = (kind == K_NMI);
                    bd_we        = !exl;
                end
                CLS_DBG: begin
                    depc_we     = 1'b1;
                    depc_val    = (kind == K_DSS) ? pc : pc_back;
                    enter_debug = 1'b1;
                    bd_we       = !exl;
                    for (int i = 0; i < DBG_W; i++) begin
                        dbg_bits[i] = (kind == kind_e'(int'(K_DSS) + i));
                    end
                end
                default: begin
                    code_we = 1'b1;
                    code    = code_of(kind);
                    if (!exl) begin
                        epc_we  = 1'b1;
                        epc_val = pc_back;
                        bd_we   = 1'b1;
                        bd_val  = in_delay;
                        set_exl = 1'b1;
                    end
                    if (kind == K_COPU) begin
                        ce_we  = 1'b1;
                        ce_val = cop_num;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry sequencer top: arbitrates requests, computes the handler
// address and state updates, and registers them with a one-cycle commit.
// Assumes inputs are stable in the cycle the request is presented.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] req,
    input  logic [1:0]           cop_num,
    input  logic [AW-1:0]        pc,
    input  logic                 in_delay,
    input  logic                 exl,
    input  logic                 bev,
    input  logic                 iv,
    input  logic                 in_debug,
    input  logic [AW-1:0]        ebase,
    output logic                 commit,
    output logic [AW-1:0]        next_pc,
    output logic                 epc_we,
    output logic [AW-1:0]        epc_val,
    output logic                 errepc_we,
    output logic [AW-1:0]        errepc_val,
    output logic                 depc_we,
    output logic [AW-1:0]        depc_val,
    output logic                 code_we,
    output logic [CODE_W-1:0]    code,
    output logic                 bd_we,
    output logic                 bd_val,
    output logic                 ce_we,
    output logic [1:0]           ce_val,
    output logic                 set_exl,
    output logic                 set_erl,
    output logic                 set_bev,
    output logic                 set_nmi_flag,
    output logic                 set_sr_flag,
    output logic [DBG_W-1:0]     dbg_bits,
    output logic                 enter_debug,
    output logic                 clear_delay,
    output logic                 force_kernel
);
    logic              hit;
    logic [KIND_W-1:0] win;
    kind_e             kind;
    logic [AW-1:0]     n_pc, n_epc, n_errepc, n_depc;
    logic              n_epc_we, n_errepc_we, n_depc_we, n_code_we;
    logic [CODE_W-1:0] n_code;
    logic              n_bd_we, n_bd, n_ce_we;
    logic [1:0]        n_ce;
    logic              n_exl, n_erl, n_bev, n_nmi, n_sr, n_dbg_en;
    logic [DBG_W-1:0]  n_dbg;
    logic              n_clr, n_kern;

    exc_arbiter #(.N(NUM_KINDS)) u_arb (
        .req(req), .in_debug(in_debug), .hit(hit), .win(win)
    );

    // Present the winning index as a kind.
    always_comb kind = kind_e'(win);

    exc_vector #(.AW(AW)) u_vec (
        .hit(hit), .kind(kind), .exl(exl), .bev(bev), .iv(iv),
        .ebase(ebase), .next_pc(n_pc)
    );

    exc_capture #(.AW(AW)) u_cap (
        .hit(hit), .kind(kind), .pc(pc), .in_delay(in_delay), .exl(exl),
        .cop_num(cop_num),
        .epc_we(n_epc_we), .epc_val(n_epc),
        .errepc_we(n_errepc_we), .errepc_val(n_errepc),
        .depc_we(n_depc_we), .depc_val(n_depc),
        .code_we(n_code_we), .code(n_code),
        .bd_we(n_bd_we), .bd_val(n_bd), .ce_we(n_ce_we), .ce_val(n_ce),
        .set_exl(n_exl), .set_erl(n_erl), .set_bev(n_bev),
        .set_nmi_flag(n_nmi), .set_sr_flag(n_sr), .dbg_bits(n_dbg),
        .enter_debug(n_dbg_en), .clear_delay(n_clr), .force_kernel(n_kern)
    );

    // Register the strobes every cycle; they are zero when nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= 1'b0; epc_we <= 1'b0; errepc_we <= 1'b0;
            depc_we <= 1'b0; code_we <= 1'b0; bd_we <= 1'b0; ce_we <= 1'b0;
            set_exl <= 1'b0; set_erl <= 1'b0; set_bev <= 1'b0;
            set_nmi_flag <= 1'b0; set_sr_flag <= 1'b0; dbg_bits <= '0;
            enter_debug <= 1'b0; clear_delay <= 1'b0; force_kernel <= 1'b0;
        end else begin
            commit <= hit; epc_we <= n_epc_we; errepc_we <= n_errepc_we;
            depc_we <= n_depc_we; code_we <= n_code_we; bd_we <= n_bd_we;
            ce_we <= n_ce_we; set_exl <= n_exl; set_erl <= n_erl;
            set_bev <= n_bev; set_nmi_flag <= n_nmi; set_sr_flag <= n_sr;
            dbg_bits <= n_dbg; enter_debug <= n_dbg_en;
            clear_delay <= n_clr; force_kernel <= n_kern;
        end
    end

    // Register the data values only when an entry is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc <= '0; epc_val <= '0; errepc_val <= '0; depc_val <= '0;
            code <= '0; bd_val <= 1'b0; ce_val <= '0;
        end else if (hit) begin
            next_pc <= n_pc; epc_val <= n_epc; errepc_val <= n_errepc;
            depc_val <= n_depc; code <= n_code; bd_val <= n_bd; ce_val <= n_ce;
        end
    end
endmodule

// File: rtl/exc_entry_unit_chk.sv
// Checker: temporal properties of the exception entry sequencer, attached
// to every instance of the top module by the bind below.
module exc_entry_unit_chk
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_KINDS-1:0] req,
    input logic [AW-1:0]        pc,
    input logic                 exl,
    input logic                 commit,
    input logic [AW-1:0]        next_pc,
    input logic                 epc_we,
    input logic [AW-1:0]        epc_val,
    input logic                 errepc_we,
    input logic                 depc_we,
    input logic                 code_we,
    input logic                 bd_we,
    input logic                 bd_val,
    input logic                 set_erl,
    input logic                 set_bev,
    input logic [DBG_W-1:0]     dbg_bits,
    input logic                 enter_debug,
    input logic                 clear_delay,
    input logic                 force_kernel
);
    assert_commit_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> commit);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> !(epc_we || errepc_we || depc_we || code_we || bd_we));

    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $countones({epc_we, errepc_we, depc_we}) <= 1);

    assert_delay_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) ##1 (epc_we && bd_val) |-> epc_val == $past(pc) - AW'(4));

    assert_exl_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req && exl) |=> !epc_we);

    assert_err_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && errepc_we) |-> (next_pc == AW'(32'hBFC0_0000)) && set_erl && set_bev);

    assert_dbg_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && depc_we) |-> (next_pc == AW'(32'hBFC0_0480)) && enter_debug
                                && ($countones(dbg_bits) == 1));

    assert_kernel_R13: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> clear_delay && force_kernel);
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/exc_entry_unit_test.sv
// Directed bench for the exception entry sequencer: one task per scenario.
module exc_entry_unit_test;
    localparam int AW = 32;
    localparam int NK = 27;
    // Request bit positions as listed in the requirements.
    localparam int B_SRST = 0, B_NMI = 1, B_DSS = 2, B_DDLD = 7, B_RFL_LD = 8,
                   B_ADR_LD = 13, B_IRQ = 15, B_SYSC = 18, B_BRK = 19,
                   B_COPU = 21, B_CACHE = 26;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NK-1:0] req = '0;
    logic [1:0] cop_num = '0;
    logic [AW-1:0] pc = '0, ebase = '0;
    logic in_delay = 1'b0, exl = 1'b0, bev = 1'b0, iv = 1'b0, in_debug = 1'b0;
    logic commit, epc_we, errepc_we, depc_we, code_we, bd_we, bd_val, ce_we;
    logic set_exl, set_erl, set_bev, set_nmi_flag, set_sr_flag, enter_debug;
    logic clear_delay, force_kernel;
    logic [AW-1:0] next_pc, epc_val, errepc_val, depc_val;
    logic [4:0] code;
    logic [1:0] ce_val;
    logic [5:0] dbg_bits;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exc_entry_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .cop_num(cop_num), .pc(pc),
        .in_delay(in_delay), .exl(exl), .bev(bev), .iv(iv),
        .in_debug(in_debug), .ebase(ebase), .commit(commit),
        .next_pc(next_pc), .epc_we(epc_we), .epc_val(epc_val),
        .errepc_we(errepc_we), .errepc_val(errepc_val), .depc_we(depc_we),
        .depc_val(depc_val), .code_we(code_we), .code(code), .bd_we(bd_we),
        .bd_val(bd_val), .ce_we(ce_we), .ce_val(ce_val), .set_exl(set_exl),
        .set_erl(set_erl), .set_bev(set_bev), .set_nmi_flag(set_nmi_flag),
        .set_sr_flag(set_sr_flag), .dbg_bits(dbg_bits),
        .enter_debug(enter_debug), .clear_delay(clear_delay),
        .force_kernel(force_kernel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a request for one cycle; return at the sample point of the result.
    task automatic fire(input logic [NK-1:0] r);
        @(negedge clk);
        req = r;
        @(negedge clk);
        req = '0;
    endtask

    function automatic logic [NK-1:0] bit1(input int i);
        return NK'(1) << i;
    endfunction

    task automatic t_reset;
        chk("R1 commit", 32'(commit), 0);
        chk("R1 strobes", 32'({epc_we, errepc_we, depc_we, code_we, bd_we, set_exl}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 first cycle commit", 32'(commit), 0);
    endtask

    task automatic t_syscall_boot;
        bev = 1; exl = 0; in_delay = 0; pc = 32'h8000_1000;
        fire(bit1(B_SYSC));
        chk("R2 commit", 32'(commit), 1);
        chk("R4 boot vector", next_pc, 32'hBFC0_0380);
        chk("R7 epc", epc_val, 32'h8000_1000);
        chk("R7 epc_we", 32'(epc_we), 1);
        chk("R7 bd", 32'({bd_we, bd_val}), 2);
        chk("R7 set_exl", 32'(set_exl), 1);
        chk("R9 syscall code", 32'(code), 8);
        chk("R13 kernel", 32'({clear_delay, force_kernel}), 3);
        @(negedge clk);
        chk("R2 single pulse", 32'(commit), 0);
        chk("R2 idle strobes", 32'({epc_we, code_we}), 0);
    endtask

    task automatic t_break_ebase_delay;
        bev = 0; ebase = 32'h8000_0ABC; in_delay = 1; pc = 32'h0000_1000;
        fire(bit1(B_BRK));
        chk("R4 ebase vector", next_pc, 32'h8000_0980);
        chk("R7 delay epc", epc_val, 32'h0000_0FFC);
        chk("R7 delay bd", 32'(bd_val), 1);
        chk("R9 break code", 32'(code), 9);
        in_delay = 0;
    endtask

    task automatic t_irq_iv;
        bev = 0; ebase = 32'h8000_0000; iv = 1;
        fire(bit1(B_IRQ));
        chk("R5 irq iv vector", next_pc, 32'h8000_0200);
        chk("R9 irq code", 32'({code_we, code}), 32'h20);
        iv = 0;
        fire(bit1(B_IRQ));
        chk("R5 irq default vector", next_pc, 32'h8000_0180);
    endtask

    task automatic t_refill;
        bev = 1; exl = 0;
        fire(bit1(B_RFL_LD));
        chk("R5 refill exl0", next_pc, 32'hBFC0_0200);
        chk("R9 refill code", 32'(code), 2);
        exl = 1; pc = 32'h4444_0000;
        fire(bit1(B_RFL_LD));
        chk("R5 refill exl1", next_pc, 32'hBFC0_0380);
        chk("R8 no epc", 32'({epc_we, bd_we, set_exl}), 0);
        chk("R8 code still", 32'(code_we), 1);
        exl = 0;
    endtask

    task automatic t_cache;
        bev = 1;
        fire(bit1(B_CACHE));
        chk("R6 cache bev", next_pc, 32'hBFC0_0300);
        chk("R6 cache code", 32'(code), 30);
        bev = 0; ebase = 32'h8000_0000;
        fire(bit1(B_CACHE));
        chk("R6 cache ebase", next_pc, 32'hA000_0100);
    endtask

    task automatic t_copu;
        cop_num = 2'd2;
        fire(bit1(B_COPU));
        chk("R9 copu code", 32'(code), 11);
        chk("R9 copu ce", 32'({ce_we, ce_val}), 6);
        fire(bit1(B_SYSC));
        chk("R9 no ce", 32'(ce_we), 0);
    endtask

    task automatic t_nmi_srst;
        in_delay = 1; pc = 32'h0000_2000; exl = 0;
        fire(bit1(B_NMI));
        chk("R10 errepc", errepc_val, 32'h0000_1FFC);
        chk("R10 vector", next_pc, 32'hBFC0_0000);
        chk("R10 flags", 32'({set_erl, set_bev, set_nmi_flag, set_sr_flag}), 4'b1110);
        chk("R10 bd clear", 32'({bd_we, bd_val}), 2);
        chk("R10 no epc", 32'({epc_we, code_we}), 0);
        in_delay = 0;
        fire(bit1(B_SRST));
        chk("R10 srst flags", 32'({set_nmi_flag, set_sr_flag}), 1);
        chk("R10 srst errepc", errepc_val, 32'h0000_2000);
    endtask

    task automatic t_debug;
        in_delay = 1; pc = 32'h0000_3000;
        fire(bit1(B_DDLD));
        chk("R11 depc", depc_val, 32'h0000_2FFC);
        chk("R11 bits", 32'(dbg_bits), 32'h20);
        chk("R11 vector", next_pc, 32'hBFC0_0480);
        chk("R11 enter", 32'(enter_debug), 1);
        fire(bit1(B_DSS));
        chk("R11 sstep depc", depc_val, 32'h0000_3000);
        chk("R11 sstep bit", 32'(dbg_bits), 1);
        in_delay = 0;
    endtask

    task automatic t_irq_in_debug;
        in_debug = 1;
        fire(bit1(B_IRQ));
        chk("R12 debug int bit", 32'(dbg_bits), 2);
        chk("R12 no code", 32'({code_we, depc_we}), 1);
        in_debug = 0;
    endtask

    task automatic t_priority;
        exl = 0; pc = 32'h0000_5000;
        fire(bit1(B_SRST) | bit1(B_NMI) | bit1(B_SYSC));
        chk("R3 srst over nmi", 32'({set_sr_flag, set_nmi_flag, code_we}), 4);
        fire(bit1(B_NMI) | bit1(B_DSS) | bit1(B_ADR_LD));
        chk("R3 nmi over debug", 32'({set_nmi_flag, depc_we, code_we}), 4);
        fire(bit1(B_DDLD) | bit1(B_ADR_LD));
        chk("R3 debug over addr", 32'({depc_we, code_we}), 2);
        fire(bit1(B_ADR_LD) | bit1(B_SYSC));
        chk("R3 addr over syscall", 32'(code), 4);
        in_debug = 1;
        fire(bit1(B_NMI) | bit1(B_IRQ));
        chk("R3 nmi over remapped irq", 32'({set_nmi_flag, depc_we}), 2);
        in_debug = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_syscall_boot();
        t_break_ebase_delay();
        t_irq_iv();
        t_refill();
        t_cache();
        t_copu();
        t_nmi_srst();
        t_debug();
        t_irq_in_debug();
        t_priority();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule